// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block keeps one use bit and one lock bit for each of a fixed number of physical page frames and, when asked, names a frame whose page may be evicted. It follows the second-chance clock discipline. A hand points at one frame and moves around the frames in a ring. When a frame's use bit is set, the hand clears the bit and moves on. When a frame is locked, the hand skips it and leaves its use bit as it is. The first unlocked frame whose use bit is already clear becomes the victim.

The surrounding memory manager pulses a load strobe when it fills a frame and a reference strobe when a frame is touched. It writes lock bits one frame at a time and raises a replace request when it needs a free frame. The answer comes back some cycles later as a one-cycle done strobe. With that strobe comes either the victim frame index, or a no-victim flag that means no evictable frame was found within two turns of the hand.

Top module: `clock_repl_selector`

## Requirements
- R1: Reset (synchronous, active low) clears every use bit and every lock bit, puts the hand at frame 0 and holds `victim_done` and `no_victim` low. The first request after reset therefore picks frame 0 after a single examination.
- R2: `load_valid` with `load_frame` sets that frame's use bit at the next clock edge.
- R3: `ref_valid` with `ref_frame` sets that frame's use bit at the next clock edge.
- R4: A `repl_req` sampled while the block is idle starts a search at the frame under the hand. The search examines one frame per clock edge. The victim is the first unlocked frame, in ascending circular order, whose use bit is 0. `victim_done` rises right after the edge that examines that frame, so the latency in cycles after the request cycle equals the number of frames examined.
- R5: Each unlocked frame with use bit 1 that the hand passes during a search has its use bit cleared to 0.
- R6: A frame whose lock bit is 1 is never reported as a victim. The hand passes it without changing its use bit. `lock_wr` writes `lock_set` into the lock bit of `lock_frame`.
- R7: The hand wraps from frame NUM_FRAMES-1 to frame 0.
- R8: After a search ends, the hand points at the frame after the last one examined. After a victim, that is the frame after the victim.
- R9: If 2*NUM_FRAMES frames are examined without finding a victim, `victim_done` and `no_victim` rise together and the search ends. With all frames locked this takes exactly 2*NUM_FRAMES cycles and leaves the hand where it started.
- R10: A reference or load strobe for the frame being examined in the same cycle in which the hand would clear that frame's use bit takes priority, so the use bit ends at 1.
- R11: `victim_done` is a one-cycle pulse per search. `victim_frame` is valid while `victim_done` is high and `no_victim` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_valid | input | 1 | Frame reference strobe |
| ref_frame | input | IDX_W | Frame referenced |
| load_valid | input | 1 | Frame fill strobe |
| load_frame | input | IDX_W | Frame filled |
| lock_wr | input | 1 | Lock bit write strobe |
| lock_frame | input | IDX_W | Frame whose lock bit is written |
| lock_set | input | 1 | Value written to the lock bit |
| repl_req | input | 1 | Replace request, accepted while idle |
| victim_done | output | 1 | One-cycle end-of-search strobe |
| victim_frame | output | IDX_W | Chosen frame index |
| no_victim | output | 1 | Search ended without a victim |

## Verification
The bench drives sweeps that cross locked frames. A design that treats a locked frame's use bit as clearable would later pick that frame too early, and one that ignores locks would evict a pinned page. Other sweeps pass the last frame, so a hand that fails to wrap, or that does not resume one past the victim, reports the wrong index or the wrong latency. With every frame locked, a sweep must end after exactly two turns; a missing bound would hang the request. A reference and a load that land on the frame just as the hand clears it must leave it in use, which shifts the victim one frame along. A design that lets the clear win would evict the page that was just touched.

// File: rtl/clock_repl_pkg.sv
// Shared types for the clock page replacement selector.
// Assumes nothing beyond a two-state sweep controller.
package clock_repl_pkg;

    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_SCAN = 1'b1
    } sweep_state_t;

endpackage

// File: rtl/crs_idx_decode.sv
// Index-to-one-hot decoder with enable.
// Assumes idx < NUM_FRAMES whenever en is high; out-of-range indices decode to zero.
module crs_idx_decode #(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  en,
    input  logic [IDX_W-1:0]      idx,
    output logic [NUM_FRAMES-1:0] onehot
);

    genvar g;
    generate
        for (g = 0; g < NUM_FRAMES; g++) begin : g_dec
            // One output line per frame, high when enabled and selected.
            assign onehot[g] = en && (idx == IDX_W'(g));
        end
    endgenerate

endmodule

// File: rtl/crs_frame_bank.sv
// Per-frame use and lock bit storage.
// A set request on a frame's use bit overrides a clear request in the same cycle.
// Lock bits change only through the one-hot lock write vector.
module crs_frame_bank #(
    parameter int NUM_FRAMES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] use_set,
    input  logic [NUM_FRAMES-1:0] use_clr,
    input  logic [NUM_FRAMES-1:0] lock_we,
    input  logic                  lock_val,
    output logic [NUM_FRAMES-1:0] use_bits,
    output logic [NUM_FRAMES-1:0] lock_bits
);

    genvar g;
    generate
        for (g = 0; g < NUM_FRAMES; g++) begin : g_frame
            // Use bit: set has priority over the sweep's clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    use_bits[g] <= 1'b0;
                else if (use_set[g])
                    use_bits[g] <= 1'b1;
                else if (use_clr[g])
                    use_bits[g] <= 1'b0;
            end

            // Lock bit: written only by an explicit lock write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lock_bits[g] <= 1'b0;
                else if (lock_we[g])
                    lock_bits[g] <= lock_val;
            end
        end
    endgenerate

endmodule

// File: rtl/crs_sweep_ctrl.sv
// Clock hand and search controller.
// Examines one frame per cycle while scanning. The examined frame's use and lock
// bits arrive combinationally from the frame bank. A search is bounded by
// 2*NUM_FRAMES examinations; requests that arrive while scanning are ignored.
module crs_sweep_ctrl
    import clock_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hand_use,
    input  logic             hand_lock,
    output logic [IDX_W-1:0] hand,
    output logic             clr_hand,
    output logic             done,
    output logic             none_found,
    output logic [IDX_W-1:0] victim
);

    localparam int MAX_STEPS = 2 * NUM_FRAMES;
    localparam int STEP_W    = $clog2(MAX_STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_FRAMES - 1);

    sweep_state_t      state;
    logic [STEP_W-1:0] steps;
    logic [IDX_W-1:0]  hand_nxt;
    logic              scanning;
    logic              hit;
    logic              exhausted;

    // Decode what this cycle's examination of the hand frame yields.
    always_comb begin
        scanning  = (state == SWEEP_SCAN);
        hit       = scanning && !hand_lock && !hand_use;
        clr_hand  = scanning && !hand_lock && hand_use;
        exhausted = scanning && !hit && (steps == LAST_STEP);
        hand_nxt  = (hand == LAST_IDX) ? '0 : hand + 1'b1;
    end

    // Search state, hand position, step counter and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SWEEP_IDLE;
            hand       <= '0;
            steps      <= '0;
            done       <= 1'b0;
            none_found <= 1'b0;
            victim     <= '0;
        end else begin
            done       <= 1'b0;
            none_found <= 1'b0;
            case (state)
                SWEEP_IDLE: begin
                    if (start) begin
                        state <= SWEEP_SCAN;
                        steps <= '0;
                    end
                end
                SWEEP_SCAN: begin
                    hand  <= hand_nxt;
                    steps <= steps + 1'b1;
                    if (hit) begin
                        done   <= 1'b1;
                        victim <= hand;
                        state  <= SWEEP_IDLE;
                    end else if (exhausted) begin
                        done       <= 1'b1;
                        none_found <= 1'b1;
                        state      <= SWEEP_IDLE;
                    end
                end
                default: state <= SWEEP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/clock_repl_selector.sv
// Top of the clock page replacement selector.
// Decodes reference, load, lock and sweep-clear requests into per-frame strobes,
// keeps the frame bits and runs the clock hand. Index inputs must be below NUM_FRAMES.
module clock_repl_selector #(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic             lock_wr,
    input  logic [IDX_W-1:0] lock_frame,
    input  logic             lock_set,
    input  logic             repl_req,
    output logic             victim_done,
    output logic [IDX_W-1:0] victim_frame,
    output logic             no_victim
);

    logic [NUM_FRAMES-1:0] ref_hot;
    logic [NUM_FRAMES-1:0] load_hot;
    logic [NUM_FRAMES-1:0] clr_hot;
    logic [NUM_FRAMES-1:0] lock_hot;
    logic [NUM_FRAMES-1:0] use_set;
    logic [NUM_FRAMES-1:0] use_vec;
    logic [NUM_FRAMES-1:0] lock_vec;
    logic [IDX_W-1:0]      hand;
    logic                  clr_hand;
    logic                  hand_use;
    logic                  hand_lock;

    crs_idx_decode #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_dec_ref (
        .en(ref_valid), .idx(ref_frame), .onehot(ref_hot));

    crs_idx_decode #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_dec_load (
        .en(load_valid), .idx(load_frame), .onehot(load_hot));

    crs_idx_decode #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_dec_clr (
        .en(clr_hand), .idx(hand), .onehot(clr_hot));

    crs_idx_decode #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_dec_lock (
        .en(lock_wr), .idx(lock_frame), .onehot(lock_hot));

    // Merge the two use-bit set sources and select the frame under the hand.
    always_comb begin
        use_set   = ref_hot | load_hot;
        hand_use  = use_vec[hand];
        hand_lock = lock_vec[hand];
    end

    crs_frame_bank #(.NUM_FRAMES(NUM_FRAMES)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .use_set(use_set), .use_clr(clr_hot),
        .lock_we(lock_hot), .lock_val(lock_set),
        .use_bits(use_vec), .lock_bits(lock_vec));

    crs_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(repl_req),
        .hand_use(hand_use), .hand_lock(hand_lock),
        .hand(hand), .clr_hand(clr_hand),
        .done(victim_done), .none_found(no_victim), .victim(victim_frame));

endmodule

// File: rtl/clock_repl_checker.sv
// Assertion checker for clock_repl_selector, attached with bind.
// Observes the top's ports plus the frame bit vectors and the hand.
module clock_repl_checker #(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ref_valid,
    input logic [IDX_W-1:0]      ref_frame,
    input logic                  load_valid,
    input logic [IDX_W-1:0]      load_frame,
    input logic                  victim_done,
    input logic [IDX_W-1:0]      victim_frame,
    input logic                  no_victim,
    input logic [NUM_FRAMES-1:0] use_vec,
    input logic [NUM_FRAMES-1:0] lock_vec,
    input logic [IDX_W-1:0]      hand
);

    logic [NUM_FRAMES-1:0] lock_q;
    logic [NUM_FRAMES-1:0] use_q;

    // Keep last cycle's frame bits, i.e. the values seen at the examining edge.
    always_ff @(posedge clk) begin
        lock_q <= lock_vec;
        use_q  <= use_vec;
    end

    p_load_sets_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> use_vec[$past(load_frame)]);

    p_ref_sets_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> use_vec[$past(ref_frame)]);

    p_victim_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_done && !no_victim && $past(rst_n)) |-> !use_q[victim_frame]);

    p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_done && !no_victim && $past(rst_n)) |-> !lock_q[victim_frame]);

    p_hand_after_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_done && !no_victim) |->
            (hand == ((victim_frame == IDX_W'(NUM_FRAMES - 1)) ? '0 : victim_frame + 1'b1)));

    p_none_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        no_victim |-> victim_done);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        victim_done |=> !victim_done);

endmodule

bind clock_repl_selector clock_repl_checker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_frame(ref_frame),
    .load_valid(load_valid), .load_frame(load_frame),
    .victim_done(victim_done), .victim_frame(victim_frame), .no_victim(no_victim),
    .use_vec(use_vec), .lock_vec(lock_vec), .hand(hand));

// File: tb/test_clock_repl_selector.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each search with its own model and queues
// the expectation; a monitor pops and compares on every done strobe.
module test_clock_repl_selector;

    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_frame = '0;
    logic          load_valid = 1'b0;
    logic [IW-1:0] load_frame = '0;
    logic          lock_wr = 1'b0;
    logic [IW-1:0] lock_frame = '0;
    logic          lock_set = 1'b0;
    logic          repl_req = 1'b0;
    logic          victim_done;
    logic [IW-1:0] victim_frame;
    logic          no_victim;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    bit m_use [N];
    bit m_lock[N];
    int m_hand = 0;

    typedef struct {
        int    idx;
        bit    nv;
        string req;
    } exp_t;
    exp_t sb_q[$];

    clock_repl_selector #(.NUM_FRAMES(N), .IDX_W(IW)) i_clock_repl_selector (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_frame(ref_frame),
        .load_valid(load_valid), .load_frame(load_frame),
        .lock_wr(lock_wr), .lock_frame(lock_frame), .lock_set(lock_set),
        .repl_req(repl_req),
        .victim_done(victim_done), .victim_frame(victim_frame), .no_victim(no_victim));

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare each done strobe against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && victim_done) begin
            if (sb_q.size() == 0) begin
                check(0, "R11 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(no_victim == e.nv, {e.req, " no_victim"}, int'(no_victim), int'(e.nv));
                if (!e.nv)
                    check(int'(victim_frame) == e.idx, {e.req, " victim"}, int'(victim_frame), e.idx);
            end
        end
    end

    task automatic do_load(input int f);
        @(negedge clk); load_valid = 1; load_frame = IW'(f);
        @(negedge clk); load_valid = 0;
        m_use[f] = 1;
    endtask

    task automatic do_ref(input int f);
        @(negedge clk); ref_valid = 1; ref_frame = IW'(f);
        @(negedge clk); ref_valid = 0;
        m_use[f] = 1;
    endtask

    task automatic do_lock(input int f, input bit v);
        @(negedge clk); lock_wr = 1; lock_frame = IW'(f); lock_set = v;
        @(negedge clk); lock_wr = 0;
        m_lock[f] = v;
    endtask

    // Driver: model the sweep, queue the result, drive it and check latency and pulse.
    // bump: 0 none, 1 reference, 2 load on the first examined frame.
    task automatic run_replace(input int bump, input string req);
        exp_t e;
        int h = m_hand;
        int first = m_hand;
        int lat = 0;
        int cnt = 0;
        bit seen = 0;
        e.idx = -1; e.nv = 1; e.req = req;
        for (int s = 0; s < 2 * N; s++) begin
            lat++;
            if (m_lock[h]) begin
                h = (h + 1) % N;
            end else if (m_use[h]) begin
                if (!(bump != 0 && s == 0)) m_use[h] = 0;
                h = (h + 1) % N;
            end else begin
                e.idx = h; e.nv = 0;
                h = (h + 1) % N;
                break;
            end
        end
        if (bump != 0) m_use[first] = (e.nv == 0 && e.idx == first) ? 1 : m_use[first];
        m_hand = h;
        sb_q.push_back(e);
        @(negedge clk); repl_req = 1;
        @(negedge clk); repl_req = 0;
        if (bump == 1) begin ref_valid = 1; ref_frame = IW'(first); end
        if (bump == 2) begin load_valid = 1; load_frame = IW'(first); end
        while (!seen && cnt < 100) begin
            @(negedge clk);
            ref_valid = 0; load_valid = 0;
            cnt++;
            if (victim_done) seen = 1;
        end
        check(cnt == lat, {req, " R4 latency"}, cnt, lat);
        @(negedge clk);
        check(victim_done == 0, {req, " R11 pulse width"}, int'(victim_done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_use[i] = 0; m_lock[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: outputs idle after reset.
        check(victim_done == 0 && no_victim == 0, "R1 reset outputs", int'(victim_done), 0);
        // R1: first search takes frame 0 in one examination.
        run_replace(0, "R1 first victim");
        // R2 / R5: loaded frames 1..5 are cleared, frame 6 chosen.
        for (int f = 1; f <= 5; f++) do_load(f);
        do_ref(7);
        run_replace(0, "R2 R5 sweep over loaded");
        // R3: referenced frame 7 passed over, 8 chosen.
        run_replace(0, "R3 referenced frame");
        // R6: locked frames skipped.
        do_lock(9, 1); do_lock(10, 1); do_load(11);
        run_replace(0, "R6 skip locked");
        // R7: wrap across last frame to frame 1.
        do_load(13); do_load(14); do_load(15); do_load(0);
        run_replace(0, "R7 wrap");
        // R6: locked frame keeps its use bit through a pass.
        for (int f = 2; f <= 8; f++) do_load(f);
        do_load(9);
        run_replace(0, "R6 locked pass");
        do_lock(9, 0);
        for (int f = 12; f < N; f++) do_load(f);
        for (int f = 0; f <= 8; f++) do_load(f);
        run_replace(0, "R6 R8 use kept while locked");
        // R9: everything locked, bounded search.
        for (int f = 0; f < N; f++) do_lock(f, 1);
        run_replace(0, "R9 all locked");
        for (int f = 0; f < N; f++) do_lock(f, 0);
        // R8 / R9: hand unchanged after the bounded search.
        run_replace(0, "R8 R9 hand after no victim");
        // R10: reference collides with the clear of the first frame.
        for (int f = 0; f < N; f++) do_load(f);
        run_replace(1, "R10 ref collision");
        // R10: load collides with the clear of the first frame.
        for (int f = 0; f < N; f++) do_load(f);
        run_replace(2, "R10 load collision");
        run_replace(0, "R8 follow-up");
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R11 all results seen", sb_q.size(), 0);
        finish_run();
    end

endmodule